// File: doc/BRIEF.md
# Interval Timer with Wrap-Safe Deadline

This block keeps a free-running base counter and turns it into a software-visible interval timer. A read strobe captures the base count divided by four, so the software view advances at one quarter of the clock rate. A write strobe loads a short compare value, and the block raises an interrupt once the base counter reaches the deadline built from that value.

The compare value is narrower than the counter. The deadline takes its upper bits from the current count. Its low bits are the written value scaled up by four, so the compare field plus the two scaling bits replace the low part of the count. If that candidate lies behind the current count, or ahead of it by less than a margin, it is pushed forward by one full period of the replaced field. This lets software program "the next time the low timer bits equal X" without ever producing a deadline in the past. Routing and masking of the interrupt are handled elsewhere.

Top module: `interval_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, the deadline and `irq` are cleared, `rd_data` reads 0 and the comparator is disarmed. A disarmed comparator never raises `irq`, however long the counter runs.
- R2: The base counter increases by exactly one on every clock edge out of reset. The first edge with `rst_n` high samples a count of 0.
- R3: A read strobe captures the base count sampled at that edge, shifted right by `SHIFT` (2 by default), into `rd_data`. `rd_data` holds its value until the next read strobe.
- R4: On a write strobe, the candidate deadline is the sampled count with its low `CMP_W+SHIFT` bits replaced by `wr_data` shifted left by `SHIFT`. If the candidate is below the sampled count plus `MARGIN`, the deadline is the candidate plus 2^(`CMP_W+SHIFT`); otherwise it is the candidate itself.
- R5: After a write, `irq` is set at the first clock edge where the sampled count is equal to or greater than the deadline. For an unpushed deadline D programmed at count C, it becomes visible D−C edges after the write edge.
- R6: Once set, `irq` stays high until the next write strobe. That write clears it at its own edge.
- R7: A write strobe arms the comparator. A later write replaces the deadline and re-arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the base counter advances on each rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe: captures the scaled count |
| rd_data | output | BASE_W | Base count shifted right by SHIFT, held between reads |
| wr_en | input | 1 | Write strobe: loads a new compare value |
| wr_data | input | CMP_W | Compare value in timer units |
| irq | output | 1 | Deadline-reached interrupt, sticky until the next write |

## Verification
The bench builds the block with a 24-bit base counter, an 8-bit compare field, a shift of 2 and a margin of 20. With these values the replaced field spans 1024 counts, so a push-forward by one whole period, a candidate that crosses the field boundary, and deadlines just inside and just outside the margin all occur within a few thousand cycles. The defaults would need 2^34 cycles for the same cases. At these sizes the margin boundary can be hit exactly: a candidate equal to count plus margin is kept, and one four counts lower is pushed forward.

// File: rtl/itmr_pkg.sv
// Package: itmr_pkg
// Shared default sizes for the interval timer family.
// Assumes: the compare field plus the shift fits inside the base counter.
package itmr_pkg;
    localparam int unsigned ITMR_BASE_W_DEF = 64;
    localparam int unsigned ITMR_CMP_W_DEF  = 32;
    localparam int unsigned ITMR_SHIFT_DEF  = 2;
    localparam int unsigned ITMR_MARGIN_DEF = 1000;
endpackage

// File: rtl/itmr_base_counter.sv
// Module: itmr_base_counter
// Free-running base counter and the read-capture register for the
// scaled software view of the time.
// Assumes: synchronous active-low reset; the counter wraps silently.
module itmr_base_counter #(
    parameter int unsigned BASE_W = itmr_pkg::ITMR_BASE_W_DEF,
    parameter int unsigned SHIFT  = itmr_pkg::ITMR_SHIFT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    output logic [BASE_W-1:0] count,
    output logic [BASE_W-1:0] rd_data
);
    localparam logic [BASE_W-1:0] ONE = BASE_W'(1);

    // Advance the base count once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + ONE;
    end

    // Capture the scaled count on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= count >> SHIFT;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> count == $past(count) + ONE); // R2

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R3
endmodule

// File: rtl/itmr_deadline_gen.sv
// Module: itmr_deadline_gen
// Forms the deadline from a compare write: it merges the scaled compare
// value into the low bits of the current count and pushes the result one
// field period ahead when it is behind the count or inside the margin.
// Assumes: CMP_W + SHIFT <= BASE_W; the deadline is kept one bit wider
// than the counter so the push-forward never truncates.
module itmr_deadline_gen #(
    parameter int unsigned BASE_W = itmr_pkg::ITMR_BASE_W_DEF,
    parameter int unsigned CMP_W  = itmr_pkg::ITMR_CMP_W_DEF,
    parameter int unsigned SHIFT  = itmr_pkg::ITMR_SHIFT_DEF,
    parameter int unsigned MARGIN = itmr_pkg::ITMR_MARGIN_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] count,
    input  logic              wr_en,
    input  logic [CMP_W-1:0]  wr_data,
    output logic [BASE_W:0]   deadline,
    output logic              armed
);
    localparam int unsigned FIELD_W = CMP_W + SHIFT;
    localparam int unsigned DL_W    = BASE_W + 1;
    localparam logic [DL_W-1:0] PERIOD   = DL_W'(1) << FIELD_W;
    localparam logic [DL_W-1:0] LOW_MASK = PERIOD - DL_W'(1);
    localparam logic [DL_W-1:0] MARGIN_X = DL_W'(MARGIN);

    logic [DL_W-1:0] count_x;
    logic [DL_W-1:0] candidate;
    logic [DL_W-1:0] limit;
    logic [DL_W-1:0] next_deadline;

    // Build the merged candidate and the push-forward decision.
    always_comb begin
        count_x       = {1'b0, count};
        candidate     = (count_x & ~LOW_MASK) | (DL_W'(wr_data) << SHIFT);
        limit         = count_x + MARGIN_X;
        next_deadline = (candidate < limit) ? candidate + PERIOD : candidate;
    end

    // Latch the deadline and arm the comparator on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deadline <= '0;
            armed    <= 1'b0;
        end else if (wr_en) begin
            deadline <= next_deadline;
            armed    <= 1'b1;
        end
    end

    AST_DL_FUTURE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> deadline > {1'b0, $past(count)}); // R4

    AST_ARM_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> armed); // R7

    AST_ARM_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed); // R7
endmodule

// File: rtl/itmr_match.sv
// Module: itmr_match
// Compares the base count with the armed deadline and holds the interrupt
// until software writes a new compare value.
// Assumes: the deadline is one bit wider than the count.
module itmr_match #(
    parameter int unsigned BASE_W = itmr_pkg::ITMR_BASE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] count,
    input  logic [BASE_W:0]   deadline,
    input  logic              armed,
    input  logic              wr_en,
    output logic              irq
);
    logic reached;

    // Deadline reached when the widened count is at or past it.
    always_comb reached = armed && ({1'b0, count} >= deadline);

    // Set the sticky interrupt; a write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (wr_en)   irq <= 1'b0;
        else if (reached) irq <= 1'b1;
    end

    AST_IRQ_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> armed); // R1

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> {1'b0, $past(count)} >= $past(deadline)); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !wr_en |=> irq); // R6

    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !irq); // R6
endmodule

// File: rtl/interval_timer.sv
// Module: interval_timer
// Top of the interval timer: base counter with scaled read-out, deadline
// formation on compare writes, and a sticky deadline interrupt.
// Assumes: synchronous active-low reset; MARGIN does not exceed one field
// period; interrupt masking lives outside this block.
module interval_timer #(
    parameter int unsigned BASE_W = itmr_pkg::ITMR_BASE_W_DEF,
    parameter int unsigned CMP_W  = itmr_pkg::ITMR_CMP_W_DEF,
    parameter int unsigned SHIFT  = itmr_pkg::ITMR_SHIFT_DEF,
    parameter int unsigned MARGIN = itmr_pkg::ITMR_MARGIN_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    output logic [BASE_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [CMP_W-1:0]  wr_data,
    output logic              irq
);
    logic [BASE_W-1:0] count;
    logic [BASE_W:0]   deadline;
    logic              armed;

    initial begin
        if (CMP_W + SHIFT > BASE_W)
            $error("interval_timer: compare field plus shift exceeds counter width");
    end

    itmr_base_counter #(.BASE_W(BASE_W), .SHIFT(SHIFT)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .count   (count),
        .rd_data (rd_data)
    );

    itmr_deadline_gen #(
        .BASE_W(BASE_W), .CMP_W(CMP_W), .SHIFT(SHIFT), .MARGIN(MARGIN)
    ) u_deadline (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (count),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .deadline (deadline),
        .armed    (armed)
    );

    itmr_match #(.BASE_W(BASE_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (count),
        .deadline (deadline),
        .armed    (armed),
        .wr_en    (wr_en),
        .irq      (irq)
    );
endmodule

// File: tb/interval_timer_tb_top.sv
// Bench: behavioural reference model stepped with the clock, compared on
// every cycle, plus directed timing checks at the margin boundaries.
module interval_timer_tb_top;
    localparam int BW   = 24;
    localparam int CW   = 8;
    localparam int SH   = 2;
    localparam int MG   = 20;
    localparam int FW   = CW + SH;
    localparam int CLK_P = 10;
    localparam longint CMASK = (64'd1 << BW) - 1;
    localparam longint FMASK = (64'd1 << FW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [CW-1:0] wr_data = '0;
    logic [BW-1:0] rd_data;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint m_cnt = 0, m_dl = 0, m_rd = 0;
    bit     m_arm = 0, m_irq = 0;

    interval_timer #(.BASE_W(BW), .CMP_W(CW), .SHIFT(SH), .MARGIN(MG)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .wr_en(wr_en), .wr_data(wr_data), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: apply inputs, advance the model at the edge, compare after.
    task automatic step(input bit rd, input bit wr, input longint d);
        longint cand;
        rd_en = rd; wr_en = wr; wr_data = CW'(d);
        @(posedge clk);
        if (!rst_n) begin
            m_cnt = 0; m_dl = 0; m_rd = 0; m_arm = 0; m_irq = 0;
        end else begin
            if (rd) m_rd = m_cnt >> SH;
            if (wr) begin
                cand = (m_cnt & ~FMASK) | ((d & ((64'd1 << CW) - 1)) << SH);
                if (cand < m_cnt + MG) cand = cand + (64'd1 << FW);
                m_dl = cand; m_arm = 1; m_irq = 0;
            end else if (m_arm && m_cnt >= m_dl) begin
                m_irq = 1;
            end
            m_cnt = (m_cnt + 1) & CMASK;
        end
        @(negedge clk);
        rd_en = 0; wr_en = 0;
        chk(longint'(rd_data) == m_rd, "R3 rd_data vs model", longint'(rd_data), m_rd);
        chk(irq == m_irq, "R5 irq vs model", longint'(irq), longint'(m_irq));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 3000) begin step(0, 0, 0); n++; end
    endtask

    initial begin
        int n;
        longint r1, r2, d;
        @(negedge clk);
        step(0, 0, 0); step(0, 0, 0);
        // R1: reset state at the ports.
        chk(rd_data == '0, "R1 rd_data in reset", longint'(rd_data), 0);
        chk(irq == 1'b0, "R1 irq in reset", longint'(irq), 0);
        rst_n = 1'b1;
        // R2: first read after release samples count 0.
        step(1, 0, 0);
        chk(rd_data == '0, "R2 first count is zero", longint'(rd_data), 0);
        // R1: disarmed comparator stays quiet.
        idle(1200);
        chk(irq == 1'b0, "R1 no irq while disarmed", longint'(irq), 0);
        // R2/R3: two reads eight edges apart differ by two timer units.
        step(1, 0, 0); r1 = longint'(rd_data);
        idle(7);
        step(1, 0, 0); r2 = longint'(rd_data);
        chk(r2 - r1 == 2, "R2 count advances one per clock", r2 - r1, 2);
        idle(5);
        chk(longint'(rd_data) == r2, "R3 rd_data held", longint'(rd_data), r2);

        // R4/R5: boundary, candidate equals count + margin, not pushed.
        while ((m_cnt % 4) != 0 || ((m_cnt & FMASK) + MG) >= (64'd1 << FW)) step(0, 0, 0);
        d = ((m_cnt + MG) >> SH) & ((64'd1 << CW) - 1);
        step(0, 1, d);
        chk(irq == 1'b0, "R6 write clears irq", longint'(irq), 0);
        wait_irq(n);
        chk(n == MG, "R5 irq delay at exact margin", n, MG);
        // R6: sticky for a long stretch.
        idle(300);
        chk(irq == 1'b1, "R6 irq sticky", longint'(irq), 1);

        // R4: candidate four counts inside the margin, pushed one period.
        while ((m_cnt % 4) != 0 || ((m_cnt & FMASK) + MG) >= (64'd1 << FW)) step(0, 0, 0);
        d = ((m_cnt + MG - 4) >> SH) & ((64'd1 << CW) - 1);
        step(0, 1, d);
        chk(irq == 1'b0, "R6 write clears sticky irq", longint'(irq), 0);
        wait_irq(n);
        chk(n == MG - 4 + (1 << FW), "R4 push-forward inside margin", n, MG - 4 + (1 << FW));

        // R4: candidate behind the count near the top of the field.
        while ((m_cnt & FMASK) != FMASK - 7) step(0, 0, 0);
        step(0, 1, 4);
        wait_irq(n);
        chk(n == 8 + 16, "R4 behind-count candidate wraps to next period", n, 24);

        // R7: rewrite before expiry replaces the deadline.
        while ((m_cnt % 4) != 0 || ((m_cnt & FMASK) + 400) >= (64'd1 << FW)) step(0, 0, 0);
        step(0, 1, ((m_cnt + 400) >> SH) & ((64'd1 << CW) - 1));
        idle(10);
        d = ((m_cnt + 100) >> SH) & ((64'd1 << CW) - 1);
        while ((m_cnt % 4) != 0 || ((m_cnt & FMASK) + 100) >= (64'd1 << FW)) step(0, 0, 0);
        d = ((m_cnt + 100) >> SH) & ((64'd1 << CW) - 1);
        step(0, 1, d);
        wait_irq(n);
        chk(n == 100, "R7 rewrite replaces deadline", n, 100);

        // R1: reset mid-run clears irq and rd_data, and disarms.
        step(1, 0, 0);
        rst_n = 1'b0; step(0, 0, 0); rst_n = 1'b1;
        chk(irq == 1'b0 && rd_data == '0, "R1 reset mid-run", longint'(irq), 0);
        idle(1100);
        chk(irq == 1'b0, "R1 disarmed after reset", longint'(irq), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule